// File: doc/BRIEF.md
# Up/Down Spanning-Tree Route Unit

This unit picks the output port for one packet at one router of an irregular on-chip network. An example of such a network is a stack of mesh dies with a die of random shortcut links. Deadlock is avoided with up/down routing. Each router port is configured as leading toward the root of a spanning tree ("up") or away from it ("down"). A legal path climbs for zero or more hops, then descends for zero or more hops, and never climbs again after it has descended.

Two virtual channels are supported. Each one has its own spanning tree, with its own root and its own per-port direction tags. For every destination node, each channel also has a table of allowed output ports. A single write port loads both kinds of configuration.

A request carries four fields: the destination, the port the packet arrived on, a header phase bit (clear at injection, set once the packet has gone down), and the virtual channel. One cycle later the unit returns the chosen port, the updated phase bit and an error flag. The error flag is raised when no legal port remains.

Top module: `updn_route_unit`

## Requirements
- R1: Synchronous active-high reset clears `rsp_valid`, every candidate mask and every direction tag. After reset, any request for a non-local destination reports an error.
- R2: A request whose destination equals `local_id` returns port 0 (local ejection) with `rsp_err` low and the phase bit unchanged.
- R3: When more than one port is legal, the lowest-numbered port is returned.
- R4: The arrival port is never returned for a non-local destination. Port 0 is never taken from the candidate mask.
- R5: When the incoming phase bit is 1, ports whose effective tag is up (tag bit = 1) are not legal.
- R6: The returned phase bit is the incoming phase bit ORed with "selected port is down". Taking an up port leaves the phase bit unchanged. Once the phase bit is 1, it stays 1.
- R7: Each virtual channel uses only its own candidate masks and tags, selected by `req_vc`.
- R8: When `local_id` equals the root of the request's channel (channel c's root is `root_ids[c*NODE_W +: NODE_W]`), every port is treated as down.
- R9: If no legal port remains, `rsp_err` is 1, `rsp_port` is 0 and the phase bit is unchanged.
- R10: `rsp_valid` equals the previous cycle's `req_valid`. All response fields are registered, so the latency is one cycle.
- R11: A configuration write is applied at the clock edge where `cfg_we` is high and is seen by requests in later cycles. A request in the same cycle sees the old value. `cfg_kind` = 0 writes the candidate mask for channel `cfg_vc`, destination `cfg_addr`. `cfg_kind` = 1 writes that channel's tag vector, where bit p = 1 marks port p as up, and `cfg_addr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = candidate mask, 1 = direction tags |
| cfg_vc | input | VC_W | Channel being configured |
| cfg_addr | input | NODE_W | Destination index for mask writes |
| cfg_data | input | NUM_PORTS | Mask or tag vector |
| local_id | input | NODE_W | This router's node ID |
| root_ids | input | NUM_VC*NODE_W | Tree root per channel |
| req_valid | input | 1 | Request strobe |
| req_dest | input | NODE_W | Destination node |
| req_in_port | input | PORT_W | Arrival port |
| req_phase | input | 1 | Header phase bit (1 = already descended) |
| req_vc | input | VC_W | Virtual channel |
| rsp_valid | output | 1 | Response strobe |
| rsp_port | output | PORT_W | Selected output port |
| rsp_phase | output | 1 | Updated phase bit |
| rsp_err | output | 1 | No legal port |

## Verification
The assertions assume three things about the inputs: reset is held from time zero, `req_valid` stays low while reset is active, and `req_in_port` is below `NUM_PORTS`. The bench drives requests only after reset is released and draws arrival ports from 0 to 6. Roots, tags and masks change freely, including writes in the same cycle as a request. A behavioural model predicts every response, and the model's own tables follow the same write timing.

// File: rtl/updn_route_pkg.sv
package updn_route_pkg;

    localparam int NODE_W     = 6;
    localparam int NUM_NODES  = 1 << NODE_W;
    localparam int NUM_PORTS  = 7;
    localparam int PORT_W     = $clog2(NUM_PORTS);
    localparam int NUM_VC     = 2;
    localparam int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
    localparam int LOCAL_PORT = 0;

    typedef logic [NUM_PORTS-1:0] port_mask_t;
    typedef logic [NODE_W-1:0]    node_t;
    typedef logic [PORT_W-1:0]    port_t;
    typedef logic [VC_W-1:0]      vc_t;

    typedef enum logic {
        CFG_CAND = 1'b0,
        CFG_TAGS = 1'b1
    } cfg_kind_e;

    typedef struct packed {
        node_t dest;
        port_t in_port;
        logic  phase;
        vc_t   vc;
    } route_req_t;

    typedef struct packed {
        port_t port;
        logic  phase;
        logic  err;
    } route_rsp_t;

    function automatic port_mask_t port_bit(input port_t p);
        port_mask_t m;
        m = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (p == port_t'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/updn_cfg_store.sv
module updn_cfg_store
    import updn_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  cfg_kind_e  wr_kind,
    input  vc_t        wr_vc,
    input  node_t      wr_addr,
    input  port_mask_t wr_data,
    input  vc_t        rd_vc,
    input  node_t      rd_dest,
    output port_mask_t rd_cand,
    output port_mask_t rd_up
);

    port_mask_t cand_of_vc [NUM_VC];
    port_mask_t tags_of_vc [NUM_VC];

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        port_mask_t cand_q [NUM_NODES];
        port_mask_t tags_q;
        logic       hit;

        assign hit = wr_en && (wr_vc == vc_t'(v));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int n = 0; n < NUM_NODES; n++) cand_q[n] <= '0;
                tags_q <= '0;
            end else if (hit) begin
                if (wr_kind == CFG_TAGS) tags_q <= wr_data;
                else                     cand_q[wr_addr] <= wr_data;
            end
        end

        assign cand_of_vc[v] = cand_q[rd_dest];
        assign tags_of_vc[v] = tags_q;
    end

    assign rd_cand = cand_of_vc[rd_vc];
    assign rd_up   = tags_of_vc[rd_vc];

endmodule

// File: rtl/updn_legal_mask.sv
module updn_legal_mask
    import updn_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_mask_t cand,
    input  port_mask_t up_tags,
    input  port_t      in_port,
    input  logic       phase,
    input  logic       at_root,
    output port_mask_t legal,
    output port_mask_t eff_up
);

    port_mask_t arrive_bit;
    port_mask_t climb_block;

    assign arrive_bit  = port_bit(in_port);
    assign eff_up      = at_root ? '0 : up_tags;
    assign climb_block = phase ? eff_up : '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        if (p == LOCAL_PORT) begin : g_loc
            assign legal[p] = 1'b0;
        end else begin : g_net
            assign legal[p] = cand[p] & ~arrive_bit[p] & ~climb_block[p];
        end
    end

    // R5
    no_climb_after_descent_chk: assert property (@(posedge clk) disable iff (rst)
        (phase && !at_root) |-> ((legal & up_tags) == '0));

    // R4
    no_uturn_chk: assert property (@(posedge clk) disable iff (rst)
        (legal & arrive_bit) == '0);

endmodule

// File: rtl/updn_lowest_pick.sv
module updn_lowest_pick
    import updn_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_mask_t req,
    output port_mask_t grant,
    output port_t      idx,
    output logic       any
);

    logic [NUM_PORTS:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[NUM_PORTS];

    always_comb begin
        idx = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (req[i]) idx = port_t'(i);
        end
    end

    // R3
    onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> (((grant - 1'b1) & req) == '0));

    // R3
    index_agrees_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> (grant == port_bit(idx)));

endmodule

// File: rtl/updn_route_unit.sv
module updn_route_unit
    import updn_route_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic                     cfg_kind,
    input  logic [VC_W-1:0]          cfg_vc,
    input  logic [NODE_W-1:0]        cfg_addr,
    input  logic [NUM_PORTS-1:0]     cfg_data,
    input  logic [NODE_W-1:0]        local_id,
    input  logic [NUM_VC*NODE_W-1:0] root_ids,
    input  logic                     req_valid,
    input  logic [NODE_W-1:0]        req_dest,
    input  logic [PORT_W-1:0]        req_in_port,
    input  logic                     req_phase,
    input  logic [VC_W-1:0]          req_vc,
    output logic                     rsp_valid,
    output logic [PORT_W-1:0]        rsp_port,
    output logic                     rsp_phase,
    output logic                     rsp_err
);

    route_req_t rq;
    route_rsp_t nxt, rsp_q;
    logic       valid_q;

    port_mask_t cand, up_tags, legal, eff_up, grant;
    port_t      pick_idx;
    logic       pick_any;
    logic       at_root, to_self;
    node_t      vc_root;

    assign rq = '{dest: req_dest, in_port: req_in_port,
                  phase: req_phase, vc: req_vc};

    updn_cfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_kind (cfg_kind_e'(cfg_kind)),
        .wr_vc   (cfg_vc),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_vc   (rq.vc),
        .rd_dest (rq.dest),
        .rd_cand (cand),
        .rd_up   (up_tags)
    );

    assign vc_root = root_ids[rq.vc*NODE_W +: NODE_W];
    assign at_root = (local_id == vc_root);
    assign to_self = (rq.dest == local_id);

    updn_legal_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .cand    (cand),
        .up_tags (up_tags),
        .in_port (rq.in_port),
        .phase   (rq.phase),
        .at_root (at_root),
        .legal   (legal),
        .eff_up  (eff_up)
    );

    updn_lowest_pick u_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (legal),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    always_comb begin
        nxt.port  = port_t'(LOCAL_PORT);
        nxt.phase = rq.phase;
        nxt.err   = 1'b0;
        if (!to_self) begin
            if (pick_any) begin
                nxt.port  = pick_idx;
                nxt.phase = rq.phase | ((grant & eff_up) == '0);
            end else begin
                nxt.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) rsp_q <= nxt;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_port  = rsp_q.port;
    assign rsp_phase = rsp_q.phase;
    assign rsp_err   = rsp_q.err;

    // R10
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R9
    err_ejects_local_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_port == port_t'(LOCAL_PORT)));

    // R6
    phase_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_phase)) |-> rsp_phase);

    // R2
    self_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(rst) && $past(req_dest == local_id)) |->
        (!rsp_err && rsp_port == port_t'(LOCAL_PORT)));

endmodule

// File: tb/updn_route_unit_tb.sv
module updn_route_unit_tb;
    import updn_route_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                     cfg_we = 0, cfg_kind = 0;
    logic [VC_W-1:0]          cfg_vc = 0;
    logic [NODE_W-1:0]        cfg_addr = 0;
    logic [NUM_PORTS-1:0]     cfg_data = 0;
    logic [NODE_W-1:0]        local_id = 6'd5;
    logic [NODE_W-1:0]        root0 = 6'd0, root1 = 6'd9;
    logic [NUM_VC*NODE_W-1:0] root_ids;
    logic                     req_valid = 0, req_phase = 0;
    logic [NODE_W-1:0]        req_dest = 0;
    logic [PORT_W-1:0]        req_in_port = 0;
    logic [VC_W-1:0]          req_vc = 0;
    logic                     rsp_valid, rsp_phase, rsp_err;
    logic [PORT_W-1:0]        rsp_port;

    assign root_ids = {root1, root0};

    updn_route_unit u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_vc(cfg_vc), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .local_id(local_id), .root_ids(root_ids), .req_valid(req_valid),
        .req_dest(req_dest), .req_in_port(req_in_port), .req_phase(req_phase),
        .req_vc(req_vc), .rsp_valid(rsp_valid), .rsp_port(rsp_port),
        .rsp_phase(rsp_phase), .rsp_err(rsp_err)
    );

    // behavioural reference
    logic [NUM_PORTS-1:0] m_cand [NUM_VC][NUM_NODES];
    logic [NUM_PORTS-1:0] m_tag  [NUM_VC];
    logic  exp_v = 0, exp_ph = 0, exp_e = 0;
    int    exp_p = 0;
    string cur_req = "R1", exp_req = "R1";
    bit    started = 0;
    int    n_cmp = 0, n_bad = 0;

    always @(posedge clk) begin
        started = 1;
        exp_req = cur_req;
        if (rst) begin
            exp_v = 0;
            for (int v = 0; v < NUM_VC; v++) begin
                m_tag[v] = '0;
                for (int n = 0; n < NUM_NODES; n++) m_cand[v][n] = '0;
            end
        end else begin
            exp_v = req_valid;
            if (req_valid) begin
                if (req_dest == local_id) begin
                    exp_p = 0; exp_ph = req_phase; exp_e = 0;
                end else begin
                    bit atr;
                    int best;
                    bit best_up;
                    atr = (local_id == (req_vc == 0 ? root0 : root1));
                    best = -1; best_up = 0;
                    for (int i = 1; i < NUM_PORTS; i++) begin
                        bit up;
                        up = !atr && m_tag[req_vc][i];
                        if (best < 0 && m_cand[req_vc][req_dest][i] &&
                            i != int'(req_in_port) && !(req_phase && up)) begin
                            best = i; best_up = up;
                        end
                    end
                    if (best < 0) begin
                        exp_p = 0; exp_ph = req_phase; exp_e = 1;
                    end else begin
                        exp_p = best; exp_ph = req_phase | !best_up; exp_e = 0;
                    end
                end
            end
            if (cfg_we) begin
                if (cfg_kind) m_tag[cfg_vc] = cfg_data;
                else          m_cand[cfg_vc][cfg_addr] = cfg_data;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp++;
            if (rsp_valid !== exp_v) begin
                n_bad++;
                $display("FAIL %s: rsp_valid actual %0b expected %0b", exp_req, rsp_valid, exp_v);
            end else if (exp_v && (int'(rsp_port) != exp_p || rsp_phase !== exp_ph || rsp_err !== exp_e)) begin
                n_bad++;
                $display("FAIL %s: port/phase/err actual %0d/%0b/%0b expected %0d/%0b/%0b",
                         exp_req, rsp_port, rsp_phase, rsp_err, exp_p, exp_ph, exp_e);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 0; cfg_we = 0;
    endtask

    task automatic cfg(input bit kind, input int vc, input int addr, input int data);
        @(negedge clk);
        req_valid = 0;
        cfg_we = 1; cfg_kind = kind; cfg_vc = vc[VC_W-1:0];
        cfg_addr = addr[NODE_W-1:0]; cfg_data = data[NUM_PORTS-1:0];
    endtask

    task automatic req(input string tag, input int dest, input int inp, input bit ph, input int vc);
        @(negedge clk);
        cfg_we = 0; cur_req = tag;
        req_valid = 1; req_dest = dest[NODE_W-1:0];
        req_in_port = inp[PORT_W-1:0]; req_phase = ph; req_vc = vc[VC_W-1:0];
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        req("R1", 10, 1, 0, 0);             // empty tables -> error
        req("R1", 10, 1, 0, 1);
        // R11: write and request in same cycle sees old value
        cfg(0, 0, 10, 7'b0110100);
        req_valid = 1; req_dest = 10; req_in_port = 1; req_phase = 0; req_vc = 0; cur_req = "R11";
        cfg(1, 0, 0, 7'b0100000);
        req("R3", 10, 1, 0, 0);             // ports 2,4,5 -> 2, down -> phase 1 (R6)
        req("R4", 10, 2, 0, 0);             // arrival 2 excluded -> 4
        req("R4", 10, 0, 1, 0);             // from local, port 0 never candidate
        cfg(0, 0, 11, 7'b1001000);
        cfg(1, 0, 0, 7'b0101000);
        req("R5", 11, 1, 1, 0);             // port 3 up masked -> 6
        req("R6", 11, 1, 0, 0);             // port 3 up, phase stays 0
        cfg(0, 0, 12, 7'b0001000);
        req("R9", 12, 1, 1, 0);             // only up port, phase set -> err
        req("R9", 12, 3, 0, 0);             // only candidate is arrival -> err
        req("R2", 5, 3, 1, 0);
        req("R2", 5, 2, 0, 1);
        cfg(0, 1, 11, 7'b1000001);
        cfg(1, 1, 0, 7'b1000000);
        req("R7", 11, 1, 1, 1);             // vc1: port 6 up, phase set -> err
        req("R7", 11, 1, 0, 1);             // vc1 -> 6, phase stays 0
        req("R7", 11, 1, 0, 0);             // vc0 still -> 3
        @(negedge clk); root0 = 6'd5;
        req("R8", 11, 1, 1, 0);             // root: port 3 down -> 3, phase 1
        req("R8", 12, 1, 0, 0);
        idle();
        root0 = 6'd0;
        req("R10", 11, 2, 0, 0);
        idle();
        req("R10", 11, 2, 1, 0);
        idle();
        idle();
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int r;
            @(negedge clk);
            r = $urandom_range(0, 99);
            cur_req = "R3";
            cfg_we = (r < 12);
            cfg_kind = $urandom_range(0, 3) == 0;
            cfg_vc = VC_W'($urandom_range(0, NUM_VC - 1));
            cfg_addr = NODE_W'($urandom_range(0, 15));
            cfg_data = NUM_PORTS'($urandom);
            req_valid = ($urandom_range(0, 9) < 7);
            req_dest = NODE_W'($urandom_range(0, 15));
            req_in_port = PORT_W'($urandom_range(0, NUM_PORTS - 1));
            req_phase = $urandom_range(0, 1) == 1;
            req_vc = VC_W'($urandom_range(0, NUM_VC - 1));
            if ($urandom_range(0, 49) == 0) root0 = NODE_W'($urandom_range(0, 7));
            if ($urandom_range(0, 49) == 0) root1 = NODE_W'($urandom_range(0, 7));
        end
        idle();
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule